// File: doc/BRIEF.md
# Symmetric Up/Down PWM Generator

This block is an up/down counter that produces centre-aligned pulse-width-modulated waveforms on two outputs. The counter climbs from zero to a ceiling and then descends back to zero. Each output changes state when the count equals that channel's compare value. A match on the rising slope moves the output one way and a match on the falling slope moves it the other way, so each pulse is centred on the turnaround point. The counter advances only on cycles where an external prescaler strobe is high.

The ceiling comes from one of two places, chosen by an input: a dedicated period register, or the active compare value of channel A. Writes to the compare values go into holding registers. The active copies are refreshed from those holding registers once per cycle, at one of two points. In top-reload mode this happens at the ceiling. In bottom-reload mode it happens at zero, which keeps both slopes of every period equal in length even when the ceiling changes. A one-cycle event output marks the reload tick. Each channel has a 2-bit output mode that selects off, toggle (channel A only), normal or inverted.

Top module: `dual_slope_pwm`

## Requirements
- R1: After reset the count rises by one per tick from 0 to the ceiling TOP, then falls by one per tick back to 0. Both 0 and TOP are each held for exactly one tick per period, so a period is 2·TOP ticks.
- R2: On a cycle where `tick` is low, the count holds its value. With one tick every N clocks, a period lasts 2·N·TOP clocks.
- R3: With `top_sel`=0, TOP is the period register. With `top_sel`=1, TOP is the active compare value of channel A.
- R4: A TOP below 3 is treated as 3. For example, a period register of 1 gives a period of 6 ticks.
- R5: In mode 2 (normal), a channel output goes low on a match while rising and goes high on a match while falling. It is high for 2·CMP ticks of each period.
- R6: In mode 3 (inverted), the actions are reversed. The output is high for 2·(TOP−CMP) ticks of each period.
- R7: In mode 2, CMP=0 holds the output low and CMP=TOP holds it high. Mode 3 gives the opposite constant levels.
- R8: In mode 1, with `top_sel`=1, output A toggles on each match, giving a 50% duty over 4·TOP ticks. Mode 0 drives the output low. So does mode 1 on channel B, or mode 1 on channel A with `top_sel`=0.
- R9: Writes go to holding registers. The active compare values (and a ceiling taken from channel A) reload on the tick at TOP when `freq_mode`=0, and on the tick at 0 when `freq_mode`=1. Changing A-sourced TOP from 6 to 10 gives tick spacings between reload events of 12, 16, 20 with `freq_mode`=0, and 12, 20 with `freq_mode`=1.
- R10: `evt` is high for one cycle, on a tick where the count equals TOP (`freq_mode`=0) or 0 (`freq_mode`=1), and never without a tick.
- R11: Reset clears the count, both outputs, the period register and all compare registers, and the count then rises first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler strobe; count advances when high |
| freq_mode | input | 1 | 0: reload at TOP, 1: reload at 0 |
| top_sel | input | 1 | 0: ceiling from period register, 1: from active compare A |
| period_wr | input | 1 | Period register write strobe |
| period_val | input | W | Period register write data |
| cmpa_wr | input | 1 | Compare A holding register write strobe |
| cmpa_val | input | W | Compare A write data |
| cmpb_wr | input | 1 | Compare B holding register write strobe |
| cmpb_val | input | W | Compare B write data |
| mode_a | input | 2 | Output mode for channel A |
| mode_b | input | 2 | Output mode for channel B |
| count | output | W | Current count |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| evt | output | 1 | One-cycle reload/event strobe |

## Verification
The bench builds the block with W=8 and the default floor of 3. This makes full-scale compare values and the clamped minimum ceiling reachable within short runs. Ceilings of 3 to 10 let whole periods, duty counts and reload spacings be counted exactly at both reload points. The bench generates a divide-by-8 strobe to bring the 2·N·TOP clock period within reach.

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm #(
  parameter int W       = 16,
  parameter int MIN_TOP = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         freq_mode,
  input  logic         top_sel,
  input  logic         period_wr,
  input  logic [W-1:0] period_val,
  input  logic         cmpa_wr,
  input  logic [W-1:0] cmpa_val,
  input  logic         cmpb_wr,
  input  logic [W-1:0] cmpb_val,
  input  logic [1:0]   mode_a,
  input  logic [1:0]   mode_b,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         evt
);

  localparam logic [W-1:0] FLOOR = W'(MIN_TOP);

  logic [W-1:0] period_q, bufa_q, bufb_q, acta_q, actb_q;
  logic [W-1:0] raw_top, top;
  logic         up_q, rising, at_top, at_bot, reload, hit_a, hit_b;

  assign raw_top = top_sel ? acta_q : period_q;
  assign top     = (raw_top < FLOOR) ? FLOOR : raw_top;
  assign at_top  = (count == top);
  assign at_bot  = (count == '0);
  assign reload  = tick & (freq_mode ? at_bot : at_top);
  assign evt     = reload;
  assign rising  = at_bot | (up_q & (count < top));
  assign hit_a   = tick & (count == acta_q);
  assign hit_b   = tick & (count == actb_q);

  function automatic logic wave_next(logic cur, logic [1:0] md, logic hit,
                                     logic rise, logic tog_ok);
    case (md)
      2'b00:   return 1'b0;
      2'b01:   return tog_ok ? (hit ? ~cur : cur) : 1'b0;
      2'b10:   return hit ? ~rise : cur;
      default: return hit ? rise : cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      if (up_q) begin
        if (count >= top) begin
          up_q  <= 1'b0;
          count <= count - W'(1);
        end else begin
          count <= count + W'(1);
        end
      end else if (at_bot) begin
        up_q  <= 1'b1;
        count <= W'(1);
      end else begin
        count <= count - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      bufa_q   <= '0;
      bufb_q   <= '0;
      acta_q   <= '0;
      actb_q   <= '0;
    end else begin
      if (period_wr) period_q <= period_val;
      if (cmpa_wr)   bufa_q   <= cmpa_val;
      if (cmpb_wr)   bufb_q   <= cmpb_val;
      if (reload) begin
        acta_q <= bufa_q;
        actb_q <= bufb_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_a <= 1'b0;
      wave_b <= 1'b0;
    end else begin
      wave_a <= wave_next(wave_a, mode_a, hit_a, rising, top_sel);
      wave_b <= wave_next(wave_b, mode_b, hit_b, rising, 1'b0);
    end
  end

endmodule

// File: rtl/dual_slope_pwm_chk.sv
module dual_slope_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         freq_mode,
  input logic [1:0]   mode_b,
  input logic [W-1:0] count,
  input logic         wave_b,
  input logic         evt
);

  assert_bottom_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0) |=> count == W'(1));

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + W'(1) || count == $past(count) - W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_evt_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> tick);

  assert_evt_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && freq_mode) |-> count == '0);

  assert_b_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b != 2'b10 && mode_b != 2'b11) |=> !wave_b);

endmodule

bind dual_slope_pwm dual_slope_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .freq_mode(freq_mode),
  .mode_b(mode_b), .count(count), .wave_b(wave_b), .evt(evt)
);

// File: tb/dual_slope_pwm_bench.sv
module dual_slope_pwm_bench;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, freq_mode = 1'b0, top_sel = 1'b0;
  logic period_wr = 1'b0, cmpa_wr = 1'b0, cmpb_wr = 1'b0;
  logic [W-1:0] period_val = '0, cmpa_val = '0, cmpb_val = '0;
  logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
  logic [W-1:0] count;
  logic wave_a, wave_b, evt;

  int tests = 0, fails = 0, div_n = 0, pc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_slope_pwm #(.W(W)) u_dual_slope_pwm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freq_mode(freq_mode), .top_sel(top_sel),
    .period_wr(period_wr), .period_val(period_val),
    .cmpa_wr(cmpa_wr), .cmpa_val(cmpa_val), .cmpb_wr(cmpb_wr), .cmpb_val(cmpb_val),
    .mode_a(mode_a), .mode_b(mode_b),
    .count(count), .wave_a(wave_a), .wave_b(wave_b), .evt(evt)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (div_n == 0) tick = 1'b0;
    else if (div_n == 1) tick = 1'b1;
    else begin
      tick = (pc == div_n - 1);
      pc = (pc == div_n - 1) ? 0 : pc + 1;
    end
  endtask

  task automatic wr_period(int v);
    period_wr = 1'b1; period_val = W'(v); cyc(); period_wr = 1'b0;
  endtask
  task automatic wr_a(int v);
    cmpa_wr = 1'b1; cmpa_val = W'(v); cyc(); cmpa_wr = 1'b0;
  endtask
  task automatic wr_b(int v);
    cmpb_wr = 1'b1; cmpb_val = W'(v); cyc(); cmpb_wr = 1'b0;
  endtask

  task automatic sync(int k);
    for (int i = 0; i < k; i++) begin
      int n = 0;
      do begin cyc(); n++; end while (!evt && n < 5000);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin cyc(); cmpa_wr = 1'b0; n++; end while (!evt && n < 5000);
  endtask

  task automatic measure(int n, int topv, output int ha, output int hb,
                         output int zeros, output int tops);
    ha = 0; hb = 0; zeros = 0; tops = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      ha += int'(wave_a); hb += int'(wave_b);
      if (count == '0) zeros++;
      if (int'(count) == topv) tops++;
    end
  endtask

  task automatic t_reset();
    chk("R11 count", int'(count), 0);
    chk("R11 wave_a", int'(wave_a), 0);
    chk("R11 wave_b", int'(wave_b), 0);
    div_n = 1; cyc(); cyc();
    chk("R11 first step up", int'(count), 1);
  endtask

  task automatic t_slopes();
    int ha, hb, z, t;
    freq_mode = 0; top_sel = 0; mode_a = 2'b10; mode_b = 2'b11;
    wr_period(8); wr_a(3); wr_b(2);
    sync(3);
    chk("R10 evt at TOP", int'(count), 8);
    measure(16, 8, ha, hb, z, t);
    chk("R5 normal high ticks", ha, 6);
    chk("R6 inverted high ticks", hb, 12);
    chk("R1 zero visits", z, 1);
    chk("R1 top visits", t, 1);
    freq_mode = 1; sync(3);
    chk("R10 evt at bottom", int'(count), 0);
    freq_mode = 0; sync(2);
  endtask

  task automatic t_extremes();
    int ha, hb, z, t;
    mode_a = 2'b10; mode_b = 2'b10; wr_a(0); wr_b(8);
    sync(3); measure(16, 8, ha, hb, z, t);
    chk("R7 normal cmp0 low", ha, 0);
    chk("R7 normal cmpTOP high", hb, 16);
    mode_a = 2'b11; mode_b = 2'b11;
    sync(3); measure(16, 8, ha, hb, z, t);
    chk("R7 inverted cmp0 high", ha, 16);
    chk("R7 inverted cmpTOP low", hb, 0);
  endtask

  task automatic t_toggle();
    int ha, hb, z, t;
    top_sel = 1; mode_a = 2'b01; mode_b = 2'b01; wr_a(5); wr_b(2);
    sync(3); measure(20, 5, ha, hb, z, t);
    chk("R8 toggle 50%", ha, 10);
    chk("R8 B mode1 low", hb, 0);
    chk("R3 period from compare A", z, 2);
    top_sel = 0; cyc(); cyc();
    chk("R8 A mode1 without A-top low", int'(wave_a), 0);
    mode_a = 2'b00; mode_b = 2'b00;
  endtask

  task automatic t_clamp();
    int g;
    top_sel = 0; wr_period(1); sync(2); gap(g);
    chk("R4 clamp to 3", g, 6);
  endtask

  task automatic t_prescale();
    int g, ha, hb, z, t;
    int c0, a0;
    div_n = 8; pc = 0; mode_a = 2'b10;
    wr_period(5); wr_a(2);
    sync(3); gap(g);
    chk("R2 period 2*N*TOP", g, 80);
    measure(80, 5, ha, hb, z, t);
    chk("R2 high clocks", ha, 32);
    div_n = 0; cyc();
    c0 = int'(count); a0 = int'(wave_a);
    repeat (20) cyc();
    chk("R2 count holds", int'(count), c0);
    chk("R2 wave holds", int'(wave_a), a0);
    div_n = 1;
  endtask

  task automatic t_reload(bit fm);
    int g1, g2, g3;
    freq_mode = fm; top_sel = 1; mode_a = 2'b00;
    wr_a(6); sync(3);
    cmpa_wr = 1'b1; cmpa_val = W'(10);
    gap(g1); gap(g2);
    if (!fm) begin
      gap(g3);
      chk("R9 top-reload gap1", g1, 12);
      chk("R9 top-reload uneven gap", g2, 16);
      chk("R9 top-reload gap3", g3, 20);
    end else begin
      chk("R9 bottom-reload gap1", g1, 12);
      chk("R9 bottom-reload gap2", g2, 20);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slopes();
    t_extremes();
    t_toggle();
    t_clamp();
    t_prescale();
    t_reload(1'b0);
    t_reload(1'b1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule